// File: doc/BRIEF.md
# Invisible-Mark Text Steganography Embedder

This block hides a stream of secret bits inside a stream of 16-bit Unicode text code units. It does not overwrite any bit of the carrier text. At each word-separating space (code unit 0x0020) it takes one two-bit symbol from the secret stream and writes zero, one or two invisible direction marks directly after the space. A reader who knows the rule recovers the symbol by looking at which marks follow each space. The visible text is unchanged.

All three interfaces use valid/ready handshakes. The carrier input carries a code unit and an end-of-message flag. The secret input carries one dibit per transfer. The output stream carries code units and the end-of-message flag. While the controller is in its search state, carrier units go straight to the output at one unit per clock. When marks are owed, the controller holds the carrier stalled and sends the marks first.

The controller has five states:
- `ST_SCAN` is the idle/search state. It forwards carrier units.
- `ST_RIGHT` sends a single right-to-left mark.
- `ST_LEFT` sends a single left-to-right mark.
- `ST_PAIR_L` sends the first mark of a pair.
- `ST_PAIR_R` sends the second mark of a pair.

The transitions are as follows:
- From `ST_SCAN`, a space leaves with a dibit on the same handshake. Dibit 00 stays in `ST_SCAN`. Dibit 01 goes to `ST_RIGHT`. Dibit 10 goes to `ST_LEFT`. Dibit 11 goes to `ST_PAIR_L`.
- `ST_PAIR_L` goes to `ST_PAIR_R` when its mark is accepted.
- `ST_RIGHT`, `ST_LEFT` and `ST_PAIR_R` return to `ST_SCAN` when their mark is accepted.

Top module: `mark_stego_embedder`

## Requirements
- R1: In the search state, a carrier unit that is not a space is forwarded unchanged with its last flag. `car_ready` equals `out_ready`. An unstalled stream moves one unit per clock.
- R2: A space accepted together with dibit 00 (`sec_dibit` = 2'b00, bit 1 is the earlier secret bit) is forwarded with no mark after it. The dibit is consumed.
- R3: A space accepted with dibit 2'b01 is followed directly by one code unit 0x200F.
- R4: A space accepted with dibit 2'b10 is followed directly by one code unit 0x200E.
- R5: A space accepted with dibit 2'b11 is followed directly by 0x200E and then 0x200F, on two separate output transfers.
- R6: While marks are being sent, `car_ready` is low. No carrier unit is lost, duplicated or reordered. Each mark adds exactly one stall cycle on an unstalled stream.
- R7: A space that passes while `sec_valid` is low is forwarded with no marks, and no dibit is consumed.
- R8: A dibit is consumed only on the same clock as a space transfer. `sec_ready` is never high unless a valid space is on the carrier input.
- R9: `out_last` appears exactly once per message. It is on the last carrier unit when no marks follow it. Otherwise it is on the last mark sent after that unit.
- R10: While `out_valid` is high and `out_ready` is low, the output unit is held unchanged until it is accepted.
- R11: After reset the controller is in the search state. With no carrier input, `out_valid` and `sec_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_valid | input | 1 | Carrier unit present |
| car_ready | output | 1 | Carrier unit accepted |
| car_data | input | UNIT_W | Carrier code unit |
| car_last | input | 1 | Carrier unit ends the message |
| sec_valid | input | 1 | Secret dibit present |
| sec_ready | output | 1 | Secret dibit consumed |
| sec_dibit | input | 2 | Secret symbol, bit 1 is the earlier secret bit |
| out_valid | output | 1 | Output unit present |
| out_ready | input | 1 | Downstream accepts output unit |
| out_data | output | UNIT_W | Output code unit (carrier or mark) |
| out_last | output | 1 | Output unit ends the message |

## Verification
The bench sends several kinds of text:
- Text with no spaces. This isolates the plain forwarding path and its one-unit-per-clock rate.
- A sentence whose spaces receive each of the four dibits in turn. This separates the four mark outcomes and the order within a pair.
- Spaces with the secret stream empty or exhausted. These show that a missing dibit causes no insertion and no consumption.
- A dibit offered against text without spaces. This shows that nothing is taken away from a space.

Two further cases are covered. A throttled `out_ready` pattern checks that marks and carrier units are held steady under backpressure. A message that ends on a space checks whether the end flag lands on the space or moves to the final mark.

// File: rtl/stego_pkg.sv
`timescale 1ns/1ps
package stego_pkg;

    // Controller states: search plus one per insertion outcome
    typedef enum logic [2:0] {
        ST_SCAN   = 3'd0,
        ST_RIGHT  = 3'd1,
        ST_LEFT   = 3'd2,
        ST_PAIR_L = 3'd3,
        ST_PAIR_R = 3'd4
    } emb_state_e;

    // Dibit values (bit 1 is the earlier secret bit)
    localparam logic [1:0] DIBIT_NONE  = 2'b00;
    localparam logic [1:0] DIBIT_RIGHT = 2'b01;
    localparam logic [1:0] DIBIT_LEFT  = 2'b10;
    localparam logic [1:0] DIBIT_PAIR  = 2'b11;

endpackage

// File: rtl/stego_dibit_map.sv
`timescale 1ns/1ps
module stego_dibit_map
    import stego_pkg::*;
(
    input  logic [1:0] dibit,
    output emb_state_e target
);

    always_comb begin
        unique case (dibit)
            DIBIT_NONE:  target = ST_SCAN;
            DIBIT_RIGHT: target = ST_RIGHT;
            DIBIT_LEFT:  target = ST_LEFT;
            DIBIT_PAIR:  target = ST_PAIR_L;
            default:     target = ST_SCAN;
        endcase
    end

endmodule

// File: rtl/stego_ctrl.sv
`timescale 1ns/1ps
module stego_ctrl
    import stego_pkg::*;
#(
    parameter int              UNIT_W   = 16,
    parameter logic [UNIT_W-1:0] SEP_CODE = 16'h0020,
    parameter logic [UNIT_W-1:0] RLM_CODE = 16'h200F,
    parameter logic [UNIT_W-1:0] LRM_CODE = 16'h200E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              car_valid,
    output logic              car_ready,
    input  logic [UNIT_W-1:0] car_data,
    input  logic              car_last,
    input  logic              sec_valid,
    output logic              sec_ready,
    input  logic [1:0]        sec_dibit,
    input  emb_state_e        target,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [UNIT_W-1:0] out_data,
    output logic              out_last
);

    emb_state_e state, state_nxt;
    logic       last_pend, last_nxt;
    logic       is_sep, take;

    assign is_sep = (car_data == SEP_CODE);
    assign take   = car_valid && is_sep && sec_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_SCAN;
            last_pend <= 1'b0;
        end else begin
            state     <= state_nxt;
            last_pend <= last_nxt;
        end
    end

    // Outputs and next state
    always_comb begin
        state_nxt = state;
        last_nxt  = last_pend;
        car_ready = 1'b0;
        sec_ready = 1'b0;
        out_valid = 1'b0;
        out_data  = car_data;
        out_last  = 1'b0;
        unique case (state)
            ST_SCAN: begin
                out_valid = car_valid;
                car_ready = out_ready;
                sec_ready = out_ready && car_valid && is_sep;
                out_last  = car_last && !(take && (target != ST_SCAN));
                if (out_ready && take) begin
                    state_nxt = target;
                    last_nxt  = car_last;
                end
            end
            ST_RIGHT: begin
                out_valid = 1'b1;
                out_data  = RLM_CODE;
                out_last  = last_pend;
                if (out_ready) state_nxt = ST_SCAN;
            end
            ST_LEFT: begin
                out_valid = 1'b1;
                out_data  = LRM_CODE;
                out_last  = last_pend;
                if (out_ready) state_nxt = ST_SCAN;
            end
            ST_PAIR_L: begin
                out_valid = 1'b1;
                out_data  = LRM_CODE;
                if (out_ready) state_nxt = ST_PAIR_R;
            end
            ST_PAIR_R: begin
                out_valid = 1'b1;
                out_data  = RLM_CODE;
                out_last  = last_pend;
                if (out_ready) state_nxt = ST_SCAN;
            end
            default: state_nxt = ST_SCAN;
        endcase
    end

    // R3
    right_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ready && sec_dibit == 2'b01) |=> (out_valid && out_data == RLM_CODE));

    // R5
    pair_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ready && sec_dibit == 2'b11) |=> (out_valid && out_data == LRM_CODE));

    // R5
    pair_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAIR_L && out_ready) |=> (out_valid && out_data == RLM_CODE));

    // R6
    carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ready && sec_dibit != 2'b00) |=> !car_ready);

    // R8
    dibit_at_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ready) |-> (car_valid && car_ready && car_data == SEP_CODE));

    // R9
    last_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ready && sec_dibit != 2'b00) |-> !out_last);

    // R10
    mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SCAN && out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/mark_stego_embedder.sv
`timescale 1ns/1ps
module mark_stego_embedder
    import stego_pkg::*;
#(
    parameter int                UNIT_W   = 16,
    parameter logic [UNIT_W-1:0] SEP_CODE = 16'h0020,
    parameter logic [UNIT_W-1:0] RLM_CODE = 16'h200F,
    parameter logic [UNIT_W-1:0] LRM_CODE = 16'h200E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              car_valid,
    output logic              car_ready,
    input  logic [UNIT_W-1:0] car_data,
    input  logic              car_last,
    input  logic              sec_valid,
    output logic              sec_ready,
    input  logic [1:0]        sec_dibit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [UNIT_W-1:0] out_data,
    output logic              out_last
);

    emb_state_e target;

    stego_dibit_map u_map (
        .dibit  (sec_dibit),
        .target (target)
    );

    stego_ctrl #(
        .UNIT_W   (UNIT_W),
        .SEP_CODE (SEP_CODE),
        .RLM_CODE (RLM_CODE),
        .LRM_CODE (LRM_CODE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .car_valid (car_valid),
        .car_ready (car_ready),
        .car_data  (car_data),
        .car_last  (car_last),
        .sec_valid (sec_valid),
        .sec_ready (sec_ready),
        .sec_dibit (sec_dibit),
        .target    (target),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: tb/sim_mark_stego_embedder.sv
`timescale 1ns/1ps
module sim_mark_stego_embedder;

    localparam logic [15:0] SP  = 16'h0020;
    localparam logic [15:0] RLM = 16'h200F;
    localparam logic [15:0] LRM = 16'h200E;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        car_valid, car_ready, car_last;
    logic [15:0] car_data;
    logic        sec_valid, sec_ready;
    logic [1:0]  sec_dibit;
    logic        out_valid, out_ready, out_last;
    logic [15:0] out_data;

    always #2.5 clk = ~clk;

    mark_stego_embedder u0 (
        .clk(clk), .rst_n(rst_n),
        .car_valid(car_valid), .car_ready(car_ready), .car_data(car_data), .car_last(car_last),
        .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_dibit(sec_dibit),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] car_buf [64];
    int          car_n;
    logic [1:0]  sec_buf [16];
    int          sec_n;
    logic [15:0] got_d [128];
    logic        got_l [128];
    int          got_n;
    logic [15:0] exp_d [128];
    logic        exp_l [128];
    int          exp_n, exp_k;
    int          car_idx, sec_idx, done_cyc;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic set_car(input string s);
        car_n = s.len();
        for (int i = 0; i < car_n; i++) car_buf[i] = {8'h00, s[i]};
    endtask

    task automatic clr_sec();
        sec_n = 0;
    endtask

    task automatic add_sec(input logic [1:0] d);
        sec_buf[sec_n] = d;
        sec_n++;
    endtask

    // Expected stream built from the requirements
    task automatic build_exp();
        exp_n = 0;
        exp_k = 0;
        for (int i = 0; i < car_n; i++) begin
            exp_d[exp_n] = car_buf[i]; exp_l[exp_n] = 1'b0; exp_n++;
            if (car_buf[i] == SP && exp_k < sec_n) begin
                logic [1:0] d;
                d = sec_buf[exp_k];
                exp_k++;
                if (d[1]) begin exp_d[exp_n] = LRM; exp_l[exp_n] = 1'b0; exp_n++; end
                if (d[0]) begin exp_d[exp_n] = RLM; exp_l[exp_n] = 1'b0; exp_n++; end
            end
            if (i == car_n - 1) exp_l[exp_n-1] = 1'b1;
        end
    endtask

    task automatic run_stream(input bit bp);
        int          cyc = 0;
        int          idle = 0;
        bit          stall_prev = 1'b0;
        logic [15:0] stall_d = '0;
        got_n = 0; car_idx = 0; sec_idx = 0; done_cyc = -1;
        while (cyc < 500 && !(car_idx == car_n && idle >= 4)) begin
            car_valid = (car_idx < car_n);
            car_data  = car_valid ? car_buf[car_idx] : 16'h0000;
            car_last  = car_valid && (car_idx == car_n - 1);
            sec_valid = (sec_idx < sec_n);
            sec_dibit = sec_valid ? sec_buf[sec_idx] : 2'b00;
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            #1;
            if (stall_prev)
                chk(out_valid && out_data == stall_d, "R10", "held unit", int'(out_data), int'(stall_d));
            if (sec_ready)
                chk(car_valid && car_data == SP, "R8", "sec_ready without space", int'(car_data), int'(SP));
            if (out_valid && (out_data == RLM || out_data == LRM))
                chk(!car_ready, "R6", "car_ready during mark", int'(car_ready), 0);
            stall_prev = out_valid && !out_ready;
            stall_d    = out_data;
            if (out_valid && out_ready) begin
                if (got_n < 128) begin
                    got_d[got_n] = out_data;
                    got_l[got_n] = out_last;
                    got_n++;
                end
                idle = 0;
            end else begin
                idle++;
            end
            if (car_valid && car_ready) begin
                car_idx++;
                if (car_idx == car_n) done_cyc = cyc + 1;
            end
            if (sec_valid && sec_ready) sec_idx++;
            cyc++;
            @(posedge clk); #1;
        end
        car_valid = 1'b0; sec_valid = 1'b0; out_ready = 1'b1;
    endtask

    task automatic compare(input string req);
        build_exp();
        chk(got_n == exp_n, req, "output length", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_d[i] == exp_d[i], req, $sformatf("unit %0d", i), int'(got_d[i]), int'(exp_d[i]));
            chk(got_l[i] == exp_l[i], "R9", $sformatf("last at %0d", i), int'(got_l[i]), int'(exp_l[i]));
        end
        chk(sec_idx == exp_k, req, "dibits consumed", sec_idx, exp_k);
    endtask

    task automatic t_reset();
        car_valid = 1'b0; sec_valid = 1'b1; sec_dibit = 2'b11; out_ready = 1'b1;
        #1;
        chk(!out_valid, "R11", "out_valid after reset", int'(out_valid), 0);
        chk(!sec_ready, "R11", "sec_ready after reset", int'(sec_ready), 0);
        chk(car_ready, "R11", "car_ready follows out_ready", int'(car_ready), 1);
        sec_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_plain();
        set_car("Hello"); clr_sec();
        run_stream(1'b0);
        compare("R1");
        chk(done_cyc == 5, "R1", "cycles for 5 units", done_cyc, 5);
    endtask

    task automatic t_each_dibit();
        set_car("w0 w1 w2 w3 w4"); clr_sec();
        add_sec(2'b00); add_sec(2'b01); add_sec(2'b10); add_sec(2'b11);
        run_stream(1'b0);
        compare("R2_R3_R4_R5");
        chk(got_n > 3 && got_d[3] == 16'h0077, "R2", "no mark after 00", int'(got_d[3]), 16'h0077);
        chk(got_n > 6 && got_d[6] == RLM, "R3", "mark after 01", int'(got_d[6]), int'(RLM));
        chk(got_n > 10 && got_d[10] == LRM, "R4", "mark after 10", int'(got_d[10]), int'(LRM));
        chk(got_n > 15 && got_d[14] == LRM && got_d[15] == RLM, "R5", "pair order", int'(got_d[15]), int'(RLM));
        chk(done_cyc == 18, "R6", "stall cycles per mark", done_cyc, 18);
    endtask

    task automatic t_no_secret();
        set_car("a b c"); clr_sec();
        run_stream(1'b0);
        compare("R7");
    endtask

    task automatic t_short_secret();
        set_car("a b c d"); clr_sec(); add_sec(2'b11);
        run_stream(1'b0);
        compare("R7");
    endtask

    task automatic t_backpressure();
        set_car("x y z"); clr_sec(); add_sec(2'b11); add_sec(2'b01);
        run_stream(1'b1);
        compare("R10");
    endtask

    task automatic t_last_mark();
        set_car("ab "); clr_sec(); add_sec(2'b10);
        run_stream(1'b0);
        compare("R9");
        chk(got_n == 4 && got_l[3] && !got_l[2], "R9", "last moved to mark", int'(got_l[3]), 1);
        set_car("ab "); clr_sec(); add_sec(2'b00);
        run_stream(1'b0);
        compare("R9");
        chk(got_n == 3 && got_l[2], "R9", "last on space", int'(got_l[2]), 1);
        set_car("c "); clr_sec(); add_sec(2'b11);
        run_stream(1'b1);
        compare("R9");
    endtask

    task automatic t_nonspace_dibit();
        set_car("abc"); clr_sec(); add_sec(2'b01);
        run_stream(1'b0);
        compare("R8");
        chk(sec_idx == 0, "R8", "dibit left unconsumed", sec_idx, 0);
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "WATCHDOG", "run timed out", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        car_valid = 1'b0; car_data = '0; car_last = 1'b0;
        sec_valid = 1'b0; sec_dibit = 2'b00; out_ready = 1'b1;
        car_n = 0; sec_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_plain();
        t_each_dibit();
        t_no_secret();
        t_short_secret();
        t_backpressure();
        t_last_mark();
        t_nonspace_dibit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule